// File: doc/BRIEF.md
# Conditional DMA Store-and-Notify Unit

This unit carries out one store-and-notify instruction for a single DMA channel thread. It takes a two-byte instruction made of an opcode byte and an argument byte. The opcode byte says whether the store depends on the channel's latched request type, and if it does, whether it is the single or the burst form. The argument byte names one of 32 peripherals. The unit compares the instruction's condition with the request-type flag. If they do not match, the instruction does nothing except advance the program counter. If they match, the unit issues one AXI4 write burst with data taken from the channel's data FIFO.

A burst starts only when the FIFO already holds every beat the burst needs. After the last beat, the unit waits for the write response. An OKAY response produces a one-cycle acknowledge on the named peripheral's line. The destination address then advances if the channel's increment bit is set, and the program counter moves to the next instruction. Any other response parks the unit in a fault state until reset. The destination address register is loaded through a port while the unit is idle.

Top module: `dma_stnotify`

## Requirements
- R1: An instruction is accepted on a cycle with `ins_valid` high, `busy` low, `ins_op[7:2]` equal to 6'b001010 and `ins_arg[2:0]` equal to zero. Any other byte pair is ignored: `busy` stays low and `pc` does not change.
- R2: Opcode 0x29 (the single form, with op[1]=0 and op[0]=1) with `req_burst` low writes exactly one beat. `awlen` is 0 whatever `cfg_blen` holds.
- R3: Two cases are no-ops: opcode 0x29 with `req_burst` high, and opcode 0x2B (the burst form, with op[1]=1 and op[0]=1) with `req_burst` low. In both, no address phase, no acknowledge and no destination address change occur, and `pc` still advances by 2.
- R4: Opcode 0x2B with `req_burst` high, and opcode 0x28 (unconditional, op[0]=0) for either value of `req_burst`, write `cfg_blen`+1 beats with `awlen` equal to `cfg_blen`.
- R5: `awvalid` is not raised until `fifo_count` is at least the number of beats in the burst.
- R6: The write burst has the following fields and data:
  - `awaddr` equals `dst_addr`.
  - `awsize` equals `cfg_size`.
  - `awburst` is 2'b01 when `cfg_inc` is set and 2'b00 when it is clear.
  - Beat data are the FIFO words in order, with one `fifo_rd` per accepted beat.
  - `wlast` is high only on the final beat.
- R7: After an OKAY (2'b00) write response, `ack` pulses high for exactly one cycle, on bit `ins_arg[7:3]` only.
- R8: `dst_ld` loads `dst_addr` while the unit is idle. After a completed store with `cfg_inc` set, `dst_addr` grows by (beats << `cfg_size`) bytes. With `cfg_inc` clear, it is unchanged.
- R9: `pc` resets to 0 and advances by exactly 2 once per executed or skipped instruction.
- R10: A non-OKAY write response sets `fault` and holds it until reset. While `fault` is set, there is no acknowledge, `pc` does not advance, and `busy` stays high, so no new instruction is accepted.
- R11: During and after reset, `busy`, `fault`, `ack`, `awvalid`, `wvalid`, `pc` and `dst_addr` are all zero. `busy` is high from the cycle after acceptance until `pc` has advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction bytes present |
| ins_op | input | 8 | Opcode byte |
| ins_arg | input | 8 | Argument byte, peripheral number in [7:3] |
| busy | output | 1 | Instruction in progress |
| req_burst | input | 1 | Latched request type, 1 = burst, 0 = single |
| cfg_blen | input | 4 | Destination burst length minus one |
| cfg_size | input | 3 | Destination beat size code |
| cfg_inc | input | 1 | Destination address increments |
| dst_ld | input | 1 | Load destination address |
| dst_ld_addr | input | AW | Value to load |
| dst_addr | output | AW | Destination address register |
| pc | output | PCW | Channel program counter |
| fifo_count | input | CW | Words held in the data FIFO |
| fifo_rd | output | 1 | Pop one FIFO word |
| fifo_data | input | DW | FIFO head word |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | AW | Write address |
| awlen | output | 8 | Beats minus one |
| awsize | output | 3 | Beat size |
| awburst | output | 2 | Burst type |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DW | Write data |
| wlast | output | 1 | Final beat |
| bvalid | input | 1 | Write response valid |
| bready | output | 1 | Write response ready |
| bresp | input | 2 | Write response code |
| ack | output | 32 | Per-peripheral acknowledge |
| fault | output | 1 | Error response received |

## Verification
The store is run for every combination of the three opcode forms and both request-flag values. This separates the condition logic: the executing cases give different burst lengths, and the skipping cases give a bare program counter step. Burst lengths of 1, 3, 4, 6 and 16 beats are used, with both increment settings and several beat sizes. The slave stalls on every other data cycle. Together these separate the length override, the address arithmetic and the placement of `wlast`. A FIFO filled below the burst size shows that the address phase waits for the fill. An error response shows that the acknowledge and the program counter step wait for an OKAY.

// File: rtl/stn_pkg.sv
package stn_pkg;
    localparam int PERW    = 5;
    localparam int NPERIPH = 1 << PERW;

    localparam logic [5:0] OPC_TAG     = 6'b001010;
    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0] RESP_OKAY   = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEC, ST_WAITF, ST_ADDR, ST_DATA, ST_RESP, ST_DONE, ST_FAULT
    } st_e;

    typedef struct packed {
        logic            run;
        logic [3:0]      len;
        logic [PERW-1:0] periph;
    } cmd_t;

    function automatic logic [4:0] beat_count(input logic [3:0] len);
        return {1'b0, len} + 5'd1;
    endfunction

    function automatic logic [11:0] bytes_moved(input logic [3:0] len, input logic [2:0] size);
        return {7'd0, beat_count(len)} << size;
    endfunction
endpackage

// File: rtl/stn_decode.sv
module stn_decode
    import stn_pkg::*;
(
    input  logic [7:0] op,
    input  logic [7:0] arg,
    input  logic       req_burst,
    input  logic [3:0] cfg_blen,
    output logic       hit,
    output cmd_t       cmd
);
    logic cond_on;
    logic want_burst;

    always_comb begin
        cond_on    = op[0];
        want_burst = op[1];
        hit        = (op[7:2] == OPC_TAG) && (arg[2:0] == 3'd0);
        cmd.periph = arg[7:3];
        // unconditional form always runs; conditional forms must match the flag
        cmd.run    = !cond_on || (want_burst == req_burst);
        // conditional single form overrides the configured length
        cmd.len    = (cond_on && !want_burst) ? 4'd0 : cfg_blen;
    end
endmodule

// File: rtl/stn_beats.sv
module stn_beats (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [3:0] len,
    input  logic       wready,
    output logic       wvalid,
    output logic       wlast,
    output logic       fire,
    output logic       done
);
    logic       active;
    logic [3:0] idx;
    logic [3:0] lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= 4'd0;
            lim    <= 4'd0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= 4'd0;
            lim    <= len;
        end else if (fire) begin
            if (idx == lim) active <= 1'b0;
            else            idx    <= idx + 4'd1;
        end
    end

    assign wvalid = active;
    assign wlast  = active && (idx == lim);
    assign fire   = active && wready;
    assign done   = fire && wlast;

    AST_LAST_ENDS_DATA: assert property (@(posedge clk) disable iff (rst)
        wvalid && wready && wlast |=> !wvalid); // R6
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !wvalid); // R6
endmodule

// File: rtl/stn_dstreg.sv
module stn_dstreg
    import stn_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          bump,
    input  logic          inc,
    input  logic [3:0]    len,
    input  logic [2:0]    size,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)                addr <= '0;
        else if (bump && inc)   addr <= addr + AW'(bytes_moved(len, size));
        else if (ld)            addr <= ld_val;
    end

    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
        !bump && !ld |=> $stable(addr)); // R8
endmodule

// File: rtl/dma_stnotify.sv
module dma_stnotify
    import stn_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int PCW = 32,
    parameter int CW  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ins_valid,
    input  logic [7:0]          ins_op,
    input  logic [7:0]          ins_arg,
    output logic                busy,
    input  logic                req_burst,
    input  logic [3:0]          cfg_blen,
    input  logic [2:0]          cfg_size,
    input  logic                cfg_inc,
    input  logic                dst_ld,
    input  logic [AW-1:0]       dst_ld_addr,
    output logic [AW-1:0]       dst_addr,
    output logic [PCW-1:0]      pc,
    input  logic [CW-1:0]       fifo_count,
    output logic                fifo_rd,
    input  logic [DW-1:0]       fifo_data,
    output logic                awvalid,
    input  logic                awready,
    output logic [AW-1:0]       awaddr,
    output logic [7:0]          awlen,
    output logic [2:0]          awsize,
    output logic [1:0]          awburst,
    output logic                wvalid,
    input  logic                wready,
    output logic [DW-1:0]       wdata,
    output logic                wlast,
    input  logic                bvalid,
    output logic                bready,
    input  logic [1:0]          bresp,
    output logic [NPERIPH-1:0]  ack,
    output logic                fault
);
    localparam logic [PCW-1:0] PC_STEP = PCW'(2);

    st_e        st;
    cmd_t       cmd_d, cmd_q;
    logic       hit;
    logic [2:0] size_q;
    logic       inc_q;
    logic       fifo_full_enough;
    logic       beats_start, beat_fire, beats_done;

    stn_decode u_dec (
        .op        (ins_op),
        .arg       (ins_arg),
        .req_burst (req_burst),
        .cfg_blen  (cfg_blen),
        .hit       (hit),
        .cmd       (cmd_d)
    );

    assign fifo_full_enough = int'(fifo_count) >= int'(beat_count(cmd_q.len));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cmd_q  <= '0;
            size_q <= 3'd0;
            inc_q  <= 1'b0;
            pc     <= '0;
        end else begin
            case (st)
                ST_IDLE: if (ins_valid && hit) begin
                    cmd_q  <= cmd_d;
                    size_q <= cfg_size;
                    inc_q  <= cfg_inc;
                    st     <= ST_DEC;
                end
                ST_DEC: if (cmd_q.run) st <= ST_WAITF;
                        else begin
                            pc <= pc + PC_STEP;
                            st <= ST_IDLE;
                        end
                ST_WAITF: if (fifo_full_enough) st <= ST_ADDR;
                ST_ADDR:  if (awready) st <= ST_DATA;
                ST_DATA:  if (beats_done) st <= ST_RESP;
                ST_RESP:  if (bvalid) st <= (bresp == RESP_OKAY) ? ST_DONE : ST_FAULT;
                ST_DONE: begin
                    pc <= pc + PC_STEP;
                    st <= ST_IDLE;
                end
                default: st <= ST_FAULT;
            endcase
        end
    end

    assign busy        = (st != ST_IDLE);
    assign fault       = (st == ST_FAULT);
    assign awvalid     = (st == ST_ADDR);
    assign bready      = (st == ST_RESP);
    assign beats_start = awvalid && awready;
    assign awaddr      = dst_addr;
    assign awlen       = {4'd0, cmd_q.len};
    assign awsize      = size_q;
    assign awburst     = inc_q ? BURST_INCR : BURST_FIXED;
    assign wdata       = fifo_data;
    assign fifo_rd     = beat_fire;

    stn_beats u_beats (
        .clk    (clk),
        .rst    (rst),
        .start  (beats_start),
        .len    (cmd_q.len),
        .wready (wready),
        .wvalid (wvalid),
        .wlast  (wlast),
        .fire   (beat_fire),
        .done   (beats_done)
    );

    stn_dstreg #(.AW(AW)) u_dst (
        .clk    (clk),
        .rst    (rst),
        .ld     (dst_ld && !busy),
        .ld_val (dst_ld_addr),
        .bump   (st == ST_DONE),
        .inc    (inc_q),
        .len    (cmd_q.len),
        .size   (size_q),
        .addr   (dst_addr)
    );

    always_comb begin
        ack = '0;
        if (st == ST_DONE) ack[cmd_q.periph] = 1'b1;
    end

    AST_ACK_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack)); // R7
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        |ack |=> ack == '0); // R7
    AST_PC_STEP_TWO: assert property (@(posedge clk) disable iff (rst)
        pc != $past(pc) |-> pc == $past(pc) + PC_STEP); // R9
    AST_FAULT_STICKS: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault && $stable(pc) && busy); // R10
    AST_FAULT_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        fault |-> ack == '0); // R10
    AST_AW_HELD: assert property (@(posedge clk) disable iff (rst)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen)); // R6
    AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> fifo_count != '0); // R5
endmodule

// File: tb/dma_stnotify_test.sv
`timescale 1ns/1ps
module dma_stnotify_test;
    localparam logic [31:0] DBASE = 32'hA000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [7:0]  ins_op = 8'd0, ins_arg = 8'd0;
    logic        busy;
    logic        req_burst = 1'b0;
    logic [3:0]  cfg_blen = 4'd0;
    logic [2:0]  cfg_size = 3'd0;
    logic        cfg_inc = 1'b0;
    logic        dst_ld = 1'b0;
    logic [31:0] dst_ld_addr = 32'd0;
    logic [31:0] dst_addr, pc;
    logic [4:0]  fifo_count;
    logic        fifo_rd;
    logic [31:0] fifo_data;
    logic        awvalid, awready = 1'b0;
    logic [31:0] awaddr;
    logic [7:0]  awlen;
    logic [2:0]  awsize;
    logic [1:0]  awburst;
    logic        wvalid, wready = 1'b0, wlast;
    logic [31:0] wdata;
    logic        bvalid = 1'b0, bready;
    logic [1:0]  bresp = 2'b00, resp_cfg = 2'b00;
    logic [31:0] ack;
    logic        fault;

    int errs = 0, checks = 0;
    int rd_ptr = 0, fill_total = 0;
    int aw_n = 0, w_n = 0, w_in = 0, wbad = 0, lastbad = 0;
    logic [7:0]  aw_len_s;
    logic [31:0] aw_addr_s;
    logic [2:0]  aw_size_s;
    logic [1:0]  aw_burst_s;
    logic [31:0] ack_q[$];
    logic [31:0] prev_ack = 32'd0;
    logic [31:0] exp_pc = 32'd0, exp_addr = 32'd0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_stnotify uut (.*);

    assign fifo_count = 5'(fill_total - rd_ptr);
    assign fifo_data  = DBASE + 32'(rd_ptr);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // FIFO and AXI slave model
    always @(posedge clk) begin
        if (fifo_rd) rd_ptr <= rd_ptr + 1;
        awready <= awvalid && !awready;
        wready  <= !wready;
        if (awvalid && awready) begin
            aw_n <= aw_n + 1; aw_len_s <= awlen; aw_addr_s <= awaddr;
            aw_size_s <= awsize; aw_burst_s <= awburst; w_in <= 0;
        end
        if (wvalid && wready) begin
            w_n <= w_n + 1; w_in <= w_in + 1;
            if (wdata != DBASE + 32'(w_n)) wbad <= wbad + 1;
            if (wlast != (w_in == int'(aw_len_s))) lastbad <= lastbad + 1;
        end
        if (wvalid && wready && wlast) begin bvalid <= 1'b1; bresp <= resp_cfg; end
        else if (bvalid && bready) bvalid <= 1'b0;
    end

    // scoreboard monitor: acknowledge pulses
    always @(negedge clk) begin
        if (!rst) begin
            if (|ack) begin
                if (ack_q.size() == 0) check(1'b0, "R7", "unexpected ack", 64'(ack), 64'd0);
                else begin
                    logic [31:0] e;
                    e = ack_q.pop_front();
                    check(ack == e, "R7", "ack line", 64'(ack), 64'(e));
                end
                check(prev_ack == 32'd0, "R7", "ack longer than a cycle", 64'(prev_ack), 64'd0);
            end
            prev_ack = ack;
        end
    end

    task automatic run_store(input logic [7:0] op, input logic [4:0] per, input bit req,
                             input logic [3:0] blen, input logic [2:0] size, input bit inc,
                             input bit exp_run, input logic [3:0] exp_len,
                             input int prefill, input string tag);
        int aw0, w0, beats;
        logic [31:0] addr0;
        beats = int'(exp_len) + 1;
        @(negedge clk);
        aw0 = aw_n; w0 = w_n; addr0 = dst_addr;
        req_burst = req; cfg_blen = blen; cfg_size = size; cfg_inc = inc;
        fill_total = rd_ptr + ((exp_run && prefill < 0) ? beats : (exp_run ? prefill : 0));
        ins_op = op; ins_arg = {per, 3'b000}; ins_valid = 1'b1;
        if (exp_run) ack_q.push_back(32'd1 << per);
        @(negedge clk);
        ins_valid = 1'b0;
        check(busy == 1'b1, "R11", {tag, " busy after accept"}, 64'(busy), 64'd1);
        if (exp_run && prefill >= 0 && prefill < beats) begin
            repeat (10) @(negedge clk);
            check(awvalid == 1'b0 && aw_n == aw0, "R5", {tag, " address phase before fill"},
                  64'(awvalid), 64'd0);
            fill_total = rd_ptr + beats;
        end
        while (busy) @(negedge clk);
        exp_pc = exp_pc + 32'd2;
        check(pc == exp_pc, "R9", {tag, " pc"}, 64'(pc), 64'(exp_pc));
        check(aw_n - aw0 == (exp_run ? 1 : 0), exp_run ? "R4" : "R3",
              {tag, " address phases"}, 64'(aw_n - aw0), 64'(exp_run));
        if (exp_run) begin
            check(aw_len_s == {4'd0, exp_len}, exp_len == 0 ? "R2" : "R4", {tag, " awlen"},
                  64'(aw_len_s), 64'(exp_len));
            check(w_n - w0 == beats, "R4", {tag, " beat count"}, 64'(w_n - w0), 64'(beats));
            check(aw_size_s == size && aw_addr_s == addr0 && aw_burst_s == (inc ? 2'b01 : 2'b00),
                  "R6", {tag, " size/addr/burst"}, {aw_size_s, aw_burst_s, aw_addr_s},
                  {size, (inc ? 2'b01 : 2'b00), addr0});
            check(wbad == 0 && lastbad == 0, "R6", {tag, " data order and wlast"},
                  64'(wbad + lastbad), 64'd0);
            if (inc) exp_addr = addr0 + (32'(beats) << size);
        end
        check(dst_addr == exp_addr, "R8", {tag, " dst_addr"}, 64'(dst_addr), 64'(exp_addr));
        check(ack_q.size() == 0, "R7", {tag, " pending acks"}, 64'(ack_q.size()), 64'd0);
    endtask

    task automatic reset_and_check;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_pc = 0; exp_addr = 0;
        check(busy == 0 && fault == 0 && ack == 0 && awvalid == 0 && wvalid == 0,
              "R11", "reset outputs", {busy, fault, awvalid, wvalid}, 64'd0);
        check(pc == 0 && dst_addr == 0, "R11", "reset pc/addr", 64'(pc), 64'd0);
    endtask

    initial begin
        reset_and_check();

        // R1: wrong opcode and nonzero reserved argument bits are ignored
        @(negedge clk);
        ins_op = 8'h30; ins_arg = 8'h18; ins_valid = 1'b1;
        @(negedge clk);
        ins_op = 8'h29; ins_arg = 8'h19;
        @(negedge clk);
        ins_valid = 1'b0;
        check(busy == 0, "R1", "foreign byte pair busy", 64'(busy), 64'd0);
        @(negedge clk);
        check(pc == 0, "R1", "foreign byte pair pc", 64'(pc), 64'd0);

        // R8: load destination
        dst_ld = 1'b1; dst_ld_addr = 32'h0000_1000;
        @(negedge clk);
        dst_ld = 1'b0;
        exp_addr = 32'h0000_1000;
        check(dst_addr == exp_addr, "R8", "load", 64'(dst_addr), 64'(exp_addr));

        run_store(8'h29, 5'd3,  1'b0, 4'd7,  3'd2, 1'b1, 1'b1, 4'd0,  -1, "R2 single match");
        run_store(8'h29, 5'd5,  1'b1, 4'd7,  3'd2, 1'b1, 1'b0, 4'd0,  -1, "R3 single vs burst flag");
        run_store(8'h2B, 5'd6,  1'b0, 4'd3,  3'd2, 1'b1, 1'b0, 4'd3,  -1, "R3 burst vs single flag");
        run_store(8'h2B, 5'd31, 1'b1, 4'd3,  3'd2, 1'b1, 1'b1, 4'd3,  -1, "R4 burst match");
        run_store(8'h28, 5'd0,  1'b0, 4'd2,  3'd1, 1'b0, 1'b1, 4'd2,  -1, "R4 uncond no-inc");
        run_store(8'h28, 5'd17, 1'b1, 4'd15, 3'd3, 1'b1, 1'b1, 4'd15, -1, "R4 uncond 16 beats");
        run_store(8'h2B, 5'd9,  1'b1, 4'd5,  3'd2, 1'b1, 1'b1, 4'd5,   3, "R5 short fifo");

        // R10: error response
        begin
            int waitc = 0;
            logic [31:0] pc0;
            pc0 = pc;
            resp_cfg = 2'b10;
            @(negedge clk);
            req_burst = 1'b0; cfg_blen = 4'd1; fill_total = rd_ptr + 2;
            ins_op = 8'h28; ins_arg = {5'd4, 3'b000}; ins_valid = 1'b1;
            @(negedge clk);
            ins_valid = 1'b0;
            while (!fault && waitc < 100) begin @(negedge clk); waitc++; end
            check(fault == 1, "R10", "fault raised", 64'(fault), 64'd1);
            check(pc == pc0 && busy == 1, "R10", "pc held and busy", 64'(pc), 64'(pc0));
            ins_op = 8'h29; ins_arg = 8'h08; ins_valid = 1'b1;
            @(negedge clk);
            ins_valid = 1'b0;
            repeat (5) @(negedge clk);
            check(pc == pc0 && fault == 1, "R10", "no accept while faulted", 64'(pc), 64'(pc0));
            resp_cfg = 2'b00;
        end

        reset_and_check();
        run_store(8'h29, 5'd12, 1'b0, 4'd4, 3'd0, 1'b1, 1'b1, 4'd0, -1, "R2 after reset");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule